// File: doc/BRIEF.md
# Masked Level Interrupt Controller with Dual Vector Outputs

The block collects up to 64 level-sensitive interrupt request inputs. Only a sparse set of request numbers is wired. Each wired request has its own enable bit in one of two 32-bit enable registers. A routing register then steers each group of requests to one of two interrupt lines, a high-priority line and a low-priority line.

For each line the block keeps a vector register. It holds the number of the lowest-numbered request that is both pending and enabled on that line, sampled once per clock.

Software reaches the block through a single-cycle register port addressed by byte offset. It enables or disables a request by read-modify-write of the enable register that holds its bit. On an interrupt it reads the vector register of the line that fired and finds the request number in the top six bits.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the routing register, both enable registers and both vector registers read zero, and both interrupt lines are low.
- R2: Register offsets are fixed: routing at 0x00, low vector at 0x04, primary enable at 0x20, secondary enable at 0x24 and high vector at 0x60. A write stores data that reads back at the same offset.
- R3: Register bits with no meaning read as zero and ignore writes. The primary enable register keeps only 0xF8F0E07E, the secondary keeps only 0x10F00000 and the routing register keeps only bits [4:0]. Offsets not listed in R2 read zero, and writes to them change no register.
- R4: Primary enable bits map to requests as follows. Requests 1, 2 and 3 use bits 15, 14 and 13. Requests 10 through 15 use bits 6 through 1, in that order. Requests 32 through 36 use bits 31 through 27. Requests 40 through 43 use bits 23 through 20. A request is enabled when its bit is 1.
- R5: Secondary enable bits map to requests as follows. Request 20 uses bit 28. Requests 25 through 28 use bits 23 through 20, in that order.
- R6: Request 0 and every request number not named in R4 or R5 never raises a line and never appears in a vector.
- R7: A vector register returns the 6-bit request number in bits [31:26] and zeros in bits [25:0]. A field of zero means nothing is pending on that line.
- R8: When several enabled requests are pending on one line, the lowest-numbered one is reported.
- R9: Requests are levels and are not latched. A vector follows the inputs one clock after they change, and it returns to zero one clock after the last enabled request drops.
- R10: Routing bit g set to 1 sends group g to the high line. Group 0 is requests 1–3, group 1 is 10–15, group 2 is 20 and 25–28, group 3 is 32–36 and group 4 is 40–43. With the routing register at zero every request goes to the low line and the high vector stays zero.
- R11: Each interrupt line is high exactly when its vector field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_src | input | 64 | Level request inputs, bit n = request n |
| irq_lo | output | 1 | Low-priority interrupt line |
| irq_hi | output | 1 | High-priority interrupt line |

## Verification
The embedded assertions check several properties on every cycle. A reported request was enabled and pending on that line one clock earlier, and no lower-numbered request was pending there. An empty request set yields a zero vector. The two lines never report the same request. A zero routing register keeps the high line quiet. Writes to undefined offsets leave all storage unchanged.

Other behaviours show only in the bench's scenarios: the exact enable-bit map of each request, the discarding of undefined bits, the bit position of the vector field, and the one-clock latency of a level change. The bench's clock-by-clock reference model compares both interrupt lines on every cycle.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants, request map and types for the interrupt controller.
// Assumes 32-bit registers and at most 64 request numbers (6-bit vector field).
package irq_ctrl_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int GRP_N   = 5;

    // Byte offsets of the register port.
    localparam logic [ADDR_W-1:0] OFF_ROUTE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_VEC_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_EN_PRI = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_EN_SEC = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_VEC_HI = 8'h60;

    // Where a request number finds its enable bit and its routing group.
    typedef struct packed {
        logic       valid;
        logic       secondary;
        logic [4:0] bitpos;
        logic [2:0] group;
    } src_map_t;

    // Computes the map entry of one request number; unlisted numbers are invalid.
    function automatic src_map_t src_map(input int n);
        src_map_t m;
        m = '0;
        if (n >= 1 && n <= 3) begin
            m.valid = 1'b1; m.bitpos = 5'(16 - n); m.group = 3'd0;
        end else if (n >= 10 && n <= 15) begin
            m.valid = 1'b1; m.bitpos = 5'(16 - n); m.group = 3'd1;
        end else if (n == 20) begin
            m.valid = 1'b1; m.secondary = 1'b1; m.bitpos = 5'd28; m.group = 3'd2;
        end else if (n >= 25 && n <= 28) begin
            m.valid = 1'b1; m.secondary = 1'b1; m.bitpos = 5'(48 - n); m.group = 3'd2;
        end else if (n >= 32 && n <= 36) begin
            m.valid = 1'b1; m.bitpos = 5'(63 - n); m.group = 3'd3;
        end else if (n >= 40 && n <= 43) begin
            m.valid = 1'b1; m.bitpos = 5'(63 - n); m.group = 3'd4;
        end
        return m;
    endfunction

    // Builds the set of defined bits in one enable register from the map.
    function automatic logic [REG_W-1:0] defined_bits(input logic secondary, input int nsrc);
        logic [REG_W-1:0] d;
        src_map_t m;
        d = '0;
        for (int n = 0; n < nsrc; n++) begin
            m = src_map(n);
            if (m.valid && (m.secondary == secondary)) d[m.bitpos] = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_ctrl_regs.sv
// Module: register file and read mux of the interrupt controller.
// Holds the routing and both enable registers; undefined bits are never stored.
// Assumes single-cycle accesses: a write takes effect at the clock edge of its cycle,
// read data is combinational from the current register state.
module irq_ctrl_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [VEC_W-1:0]  vec_lo,
    input  logic [VEC_W-1:0]  vec_hi,
    output logic [GRP_N-1:0]  route_q,
    output logic [REG_W-1:0]  en_pri_q,
    output logic [REG_W-1:0]  en_sec_q,
    output logic [REG_W-1:0]  bus_rdata
);
    localparam logic [REG_W-1:0] PRI_DEF = defined_bits(1'b0, NUM_SRC);
    localparam logic [REG_W-1:0] SEC_DEF = defined_bits(1'b1, NUM_SRC);
    localparam int               PAD_W   = REG_W - VEC_W;

    logic wr_en;
    logic rd_en;
    logic addr_known;
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    // Flags offsets that have a register behind them.
    always_comb begin
        addr_known = (bus_addr == OFF_ROUTE)  || (bus_addr == OFF_VEC_LO) ||
                     (bus_addr == OFF_EN_PRI) || (bus_addr == OFF_EN_SEC) ||
                     (bus_addr == OFF_VEC_HI);
    end

    // Stores writes to the routing and enable registers, keeping defined bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q  <= '0;
            en_pri_q <= '0;
            en_sec_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFF_ROUTE)  route_q  <= bus_wdata[GRP_N-1:0];
            if (bus_addr == OFF_EN_PRI) en_pri_q <= bus_wdata & PRI_DEF;
            if (bus_addr == OFF_EN_SEC) en_sec_q <= bus_wdata & SEC_DEF;
        end
    end

    // Selects read data by offset; vectors sit in the top bits of the word.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFF_ROUTE:  bus_rdata = {{(REG_W-GRP_N){1'b0}}, route_q};
                OFF_VEC_LO: bus_rdata = {vec_lo, {PAD_W{1'b0}}};
                OFF_EN_PRI: bus_rdata = en_pri_q;
                OFF_EN_SEC: bus_rdata = en_sec_q;
                OFF_VEC_HI: bus_rdata = {vec_hi, {PAD_W{1'b0}}};
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_UNDEF_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_known) |=> ($stable(route_q) && $stable(en_pri_q) && $stable(en_sec_q))); // R3
    AST_VEC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == OFF_VEC_LO || bus_addr == OFF_VEC_HI))
        |=> ($stable(route_q) && $stable(en_pri_q) && $stable(en_sec_q))); // R3

endmodule

// File: rtl/irq_ctrl_enable_map.sv
// Module: applies enable bits and routing to the raw request levels.
// Produces one request set per output line; unmapped request numbers are tied off.
// Assumes the request map of irq_ctrl_pkg; purely combinational.
module irq_ctrl_enable_map
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [REG_W-1:0]   en_pri_q,
    input  logic [REG_W-1:0]   en_sec_q,
    input  logic [GRP_N-1:0]   route_q,
    output logic [NUM_SRC-1:0] req_lo,
    output logic [NUM_SRC-1:0] req_hi
);
    localparam logic [REG_W-1:0] PRI_DEF = defined_bits(1'b0, NUM_SRC);
    localparam logic [REG_W-1:0] SEC_DEF = defined_bits(1'b1, NUM_SRC);

    logic [NUM_SRC-1:0] tied_off;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam src_map_t M = src_map(n);
        if (M.valid) begin : g_wired
            logic enabled;
            logic to_hi;
            // Picks the enable bit and routing bit of this request.
            always_comb begin
                enabled = M.secondary ? en_sec_q[M.bitpos] : en_pri_q[M.bitpos];
                to_hi   = route_q[M.group];
            end
            assign req_lo[n]   = irq_src[n] & enabled & ~to_hi;
            assign req_hi[n]   = irq_src[n] & enabled & to_hi;
            assign tied_off[n] = 1'b0;
        end else begin : g_absent
            assign req_lo[n]   = 1'b0;
            assign req_hi[n]   = 1'b0;
            assign tied_off[n] = irq_src[n];
        end
    end

    logic unused_inputs;
    assign unused_inputs = ^{tied_off, en_pri_q & ~PRI_DEF, en_sec_q & ~SEC_DEF};

endmodule

// File: rtl/irq_ctrl_prio.sv
// Module: fixed-priority encoder, lowest request number wins.
// Request 0 is never reported, so an output of zero means no request.
// Assumes bit 0 of the request set is always clear; purely combinational.
module irq_ctrl_prio #(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [VEC_W-1:0]   winner
);
    logic unused_req0;
    assign unused_req0 = req[0];

    // Scans from the top so the lowest set index is the last one kept.
    always_comb begin
        winner = '0;
        for (int i = NUM_SRC - 1; i >= 1; i--) begin
            if (req[i]) winner = VEC_W'(i);
        end
    end

endmodule

// File: rtl/irq_ctrl_top.sv
// Module: top of the masked level interrupt controller with two vector outputs.
// Registers one vector per line each clock from the enabled, routed requests;
// each line is high while its vector is nonzero.
// Assumes request inputs are synchronous to clk; synchronous active-low reset.
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [GRP_N-1:0]   route_q;
    logic [REG_W-1:0]   en_pri_q;
    logic [REG_W-1:0]   en_sec_q;
    logic [NUM_SRC-1:0] req_lo;
    logic [NUM_SRC-1:0] req_hi;
    logic [VEC_W-1:0]   win_lo;
    logic [VEC_W-1:0]   win_hi;
    logic [VEC_W-1:0]   vec_lo_q;
    logic [VEC_W-1:0]   vec_hi_q;

    irq_ctrl_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .vec_lo    (vec_lo_q),
        .vec_hi    (vec_hi_q),
        .route_q   (route_q),
        .en_pri_q  (en_pri_q),
        .en_sec_q  (en_sec_q),
        .bus_rdata (bus_rdata)
    );

    irq_ctrl_enable_map #(.NUM_SRC(NUM_SRC)) map_i (
        .irq_src  (irq_src),
        .en_pri_q (en_pri_q),
        .en_sec_q (en_sec_q),
        .route_q  (route_q),
        .req_lo   (req_lo),
        .req_hi   (req_hi)
    );

    irq_ctrl_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) prio_lo_i (
        .req    (req_lo),
        .winner (win_lo)
    );

    irq_ctrl_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) prio_hi_i (
        .req    (req_hi),
        .winner (win_hi)
    );

    // Samples both winners once per clock into the vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_lo_q <= '0;
            vec_hi_q <= '0;
        end else begin
            vec_lo_q <= win_lo;
            vec_hi_q <= win_hi;
        end
    end

    // Drives each line from its registered vector.
    always_comb begin
        irq_lo = (vec_lo_q != '0);
        irq_hi = (vec_hi_q != '0);
    end

    // Delayed copies of the request sets and routing, used only by assertions.
    logic [NUM_SRC-1:0] req_lo_d;
    logic [NUM_SRC-1:0] req_hi_d;
    logic [GRP_N-1:0]   route_d;
    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    // Keeps one-clock-old request sets for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_lo_d <= '0;
            req_hi_d <= '0;
            route_d  <= '0;
        end else begin
            req_lo_d <= req_lo;
            req_hi_d <= req_hi;
            route_d  <= route_q;
        end
    end

    AST_LO_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_lo_q != '0) |-> req_lo_d[vec_lo_q]); // R6
    AST_HI_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hi_q != '0) |-> req_hi_d[vec_hi_q]); // R6
    AST_LO_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_lo_q != '0) |-> ((req_lo_d & ((ONE << vec_lo_q) - ONE)) == '0)); // R8
    AST_HI_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hi_q != '0) |-> ((req_hi_d & ((ONE << vec_hi_q) - ONE)) == '0)); // R8
    AST_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lo_d == '0) |-> (vec_lo_q == '0)); // R9
    AST_LINES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_lo_q != '0) |-> (vec_lo_q != vec_hi_q)); // R10
    AST_ROUTE_ZERO_HI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (route_d == '0) |-> !irq_hi); // R10

endmodule

// File: tb/irq_ctrl_top_tb_top.sv
// Bench: behavioural clock-by-clock model of the controller, compared on every clock,
// plus directed register-level scenarios.
module irq_ctrl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_lo;
    logic        irq_hi;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Model state.
    logic [31:0] m_pri, m_sec;
    logic [4:0]  m_route;
    int          exp_lo, exp_hi;

    // Returns register*32+bit for a request, or -1 when it has no enable bit (R4, R5).
    function automatic int bit_of(input int n);
        case (n)
            1: return 15;  2: return 14;  3: return 13;
            10: return 6;  11: return 5;  12: return 4;
            13: return 3;  14: return 2;  15: return 1;
            32: return 31; 33: return 30; 34: return 29; 35: return 28; 36: return 27;
            40: return 23; 41: return 22; 42: return 21; 43: return 20;
            20: return 32 + 28;
            25: return 32 + 23; 26: return 32 + 22; 27: return 32 + 21; 28: return 32 + 20;
            default: return -1;
        endcase
    endfunction

    // Returns the routing group of a request (R10).
    function automatic int group_of(input int n);
        if (n <= 3) return 0;
        if (n <= 15) return 1;
        if (n <= 28) return 2;
        if (n <= 36) return 3;
        return 4;
    endfunction

    // Expected vector of one line from the current model state.
    function automatic int model_vec(input bit hi);
        int b;
        logic en;
        for (int n = 1; n < 64; n++) begin
            b = bit_of(n);
            if (b >= 0 && irq_src[n]) begin
                en = (b >= 32) ? m_sec[b-32] : m_pri[b];
                if (en && (m_route[group_of(n)] == hi)) return n;
            end
        end
        return 0;
    endfunction

    // Advances the reference model at each clock edge.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_pri <= '0; m_sec <= '0; m_route <= '0; exp_lo <= 0; exp_hi <= 0;
        end else begin
            exp_lo <= model_vec(1'b0);
            exp_hi <= model_vec(1'b1);
            if (bus_sel && bus_wr) begin
                if (bus_addr == 8'h00) m_route <= bus_wdata[4:0];
                if (bus_addr == 8'h20) m_pri <= bus_wdata & 32'hF8F0E07E;
                if (bus_addr == 8'h24) m_sec <= bus_wdata & 32'h10F00000;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compares both lines against the model every clock (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            check("R11 irq_lo", {31'b0, irq_lo}, {31'b0, exp_lo != 0});
            check("R11 irq_hi", {31'b0, irq_hi}, {31'b0, exp_hi != 0});
        end
    end

    // Ends a hung run as a failure.
    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive(input logic [63:0] s);
        @(negedge clk);
        irq_src = s;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r, pri_save;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, r); check("R1 route", r, 32'h0);
        rd(8'h20, r); check("R1 en_pri", r, 32'h0);
        rd(8'h24, r); check("R1 en_sec", r, 32'h0);
        rd(8'h04, r); check("R1 vec_lo", r, 32'h0);
        rd(8'h60, r); check("R1 vec_hi", r, 32'h0);
        check("R1 lines", {30'b0, irq_hi, irq_lo}, 32'h0);

        // R2, R3 readback keeps only defined bits
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, r); check("R2 R3 en_pri", r, 32'hF8F0E07E);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, r); check("R2 R3 en_sec", r, 32'h10F00000);
        wr(8'h00, 32'hFFFF_FFE5); rd(8'h00, r); check("R2 R3 route", r, 32'h05);
        wr(8'h00, 32'h0);
        // R3 undefined offsets and vector writes
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, r); check("R3 undef read", r, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h00, r); check("R3 route kept", r, 32'h0);
        rd(8'h20, r); check("R3 pri kept", r, 32'hF8F0E07E);
        rd(8'h24, r); check("R3 sec kept", r, 32'h10F00000);

        // R4, R5, R6, R7 each request alone
        for (int n = 0; n < 64; n++) begin
            drive(64'd1 << n);
            rd(8'h04, r);
            if (bit_of(n) >= 0) check("R4 R5 R7 single", r, 32'(n) << 26);
            else                check("R6 unwired", r, 32'h0);
        end

        // R4 disable one request by read-modify-write
        rd(8'h20, pri_save);
        wr(8'h20, pri_save & ~32'h4000_0000);
        drive(64'd1 << 33); rd(8'h04, r); check("R4 masked 33", r, 32'h0);
        wr(8'h24, 32'h10F00000 & ~32'h0020_0000);
        drive(64'd1 << 27); rd(8'h04, r); check("R5 masked 27", r, 32'h0);
        wr(8'h20, pri_save); wr(8'h24, 32'h10F00000);

        // R8 priority
        drive((64'd1 << 43) | (64'd1 << 12) | (64'd1 << 27));
        rd(8'h04, r); check("R8 lowest", r, 32'd12 << 26);
        // R9 level follow after one clock
        @(negedge clk); irq_src = (64'd1 << 43) | (64'd1 << 27);
        rd(8'h04, r); check("R9 before edge", r, 32'd12 << 26);
        @(negedge clk);
        rd(8'h04, r); check("R9 one clock", r, 32'd27 << 26);
        irq_src = '0;
        @(negedge clk);
        rd(8'h04, r); check("R9 released", r, 32'h0);
        check("R11 lo idle", {31'b0, irq_lo}, 32'h0);

        // R10 routing
        wr(8'h00, 32'h08);
        drive((64'd1 << 33) | (64'd1 << 40) | (64'd1 << 0));
        rd(8'h60, r); check("R10 hi vec", r, 32'd33 << 26);
        rd(8'h04, r); check("R10 lo vec", r, 32'd40 << 26);
        check("R11 both lines", {30'b0, irq_hi, irq_lo}, 32'h3);
        wr(8'h00, 32'h11);
        drive((64'd1 << 2) | (64'd1 << 41) | (64'd1 << 10));
        rd(8'h60, r); check("R10 hi groups 0,4", r, 32'd2 << 26);
        rd(8'h04, r); check("R10 lo group 1", r, 32'd10 << 26);
        wr(8'h00, 32'h0);
        drive((64'd1 << 33) | (64'd1 << 40));
        rd(8'h60, r); check("R10 route zero hi", r, 32'h0);
        rd(8'h04, r); check("R10 route zero lo", r, 32'd33 << 26);

        irq_src = '0;
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule